// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight edge-signalled interrupt requests from peripherals and presents a single interrupt line to a processor. Each rising edge on a request input is latched in a pending-request register. A mask register can hold back individual inputs, and an in-service register records which inputs the processor has taken but not yet finished. The interrupt line rises only for the best pending, unmasked input, and only when nothing of equal or better rank is already being serviced. Input 0 has the best rank and input 7 the worst.

When the processor acknowledges, the controller latches an 8-bit vector onto its vector output. The upper five bits come from a programmed base and the lower three bits give the input number. In the same cycle it moves that input from pending to in-service. The processor finishes a handler by writing an end-of-interrupt command, which retires the best-ranked in-service input. A request that was held back can then fire at once.

Software reaches the block through a two-address host port: a command address (`host_addr`=0) and a data address (`host_addr`=1). A start command begins a short setup sequence that programs the vector base. Mask writes and read-back selection follow once setup is done.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset `intr_o` is 0, `vec_o` is 0, the request, in-service and mask registers are all 0, the vector base is 0, and command-port reads return the request register.
- R2: A command-port write with bit 4 set starts setup. Bit 0 of that byte records whether a mode word will follow. The next data-port write loads the vector base from its bits 7:3. The following data-port write (cascade word) is accepted with no effect. A further mode data write is consumed only when bit 0 was set. After that, data-port writes go to the mask.
- R3: A setup-start write clears every pending request bit, including one whose edge arrives in the same cycle.
- R4: A rising edge on `irq_in[n]` sets request bit n in the next cycle. The bit stays set until acknowledged. A level held high after its edge does not set the bit again.
- R5: When setup is done, a data-port write loads the mask from its low 8 bits, and a data-port read returns the mask. Acknowledge and end-of-interrupt never change the mask.
- R6: `intr_o` is 1 exactly when some request bit is set and unmasked, and no in-service bit of equal or better rank (lower or equal index) than the best such request is set. A masked request stays recorded and fires once unmasked.
- R7: An `inta_i` cycle while `intr_o` is 1 makes `vec_o` equal {base[7:3], n} from the next cycle, where n is the best pending unmasked input. In that same cycle it sets in-service bit n and clears request bit n. An `inta_i` cycle while `intr_o` is 0 changes nothing.
- R8: A command-port write of 0x20 clears the lowest-index set in-service bit. Arbitration then runs again, so `intr_o` can rise in the next cycle for a request that was blocked.
- R9: A command-port write with bit 4 clear, bit 3 set and bit 1 set selects what command-port reads return: the request register when bit 0 is 0 (0x0A), and the in-service register when bit 0 is 1 (0x0B).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 1 | 0 = command address, 1 = data address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current address (combinational) |
| irq_in | input | 8 | Edge-sensitive request inputs, bit 0 best rank |
| intr_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge from the processor, one cycle per acknowledge |
| vec_o | output | 8 | Vector latched at the last valid acknowledge |

## Verification
The bound checker watches several rules on every cycle. The interrupt line never rises without an unmasked pending bit. Every valid acknowledge adds exactly one in-service bit and latches the programmed base, and the vector holds still otherwise. Every end-of-interrupt with work in service removes exactly one bit. The mask moves only on a mask write, and a setup start empties the request register. Other behaviour needs the directed scenarios: which input wins when several are pending, the blocking of lower-ranked requests during a nested service and their release on end-of-interrupt, the setup sequence with and without a mode word, the loss of a buffered request at re-initialization, and the absence of retriggering on a held level.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   typedef enum logic [1:0] {
      ST_READY = 2'd0,
      ST_BASE  = 2'd1,
      ST_CASC  = 2'd2,
      ST_MODE  = 2'd3
   } setup_state_e;

   localparam logic [2:0] EOI_TOP = 3'b001;
endpackage

// File: rtl/prio_irq_edge.sv
module prio_irq_edge #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] rise
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= level[i];
      end
      assign rise[i] = level[i] & ~prev_q;
   end
endmodule

// File: rtl/prio_irq_find.sv
module prio_irq_find #(
   parameter int WIDTH = 8,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int N_REQ  = 8,
   parameter int VEC_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [N_REQ-1:0]  irq_in,
   output logic              intr_o,
   input  logic              inta_i,
   output logic [VEC_W-1:0]  vec_o
);
   localparam int IDX_W  = $clog2(N_REQ);
   localparam int BASE_W = VEC_W - IDX_W;

   if (N_REQ < 2 || (1 << IDX_W) != N_REQ) begin : g_bad_nreq
      $error("N_REQ must be a power of two of at least 2");
   end
   if (VEC_W <= IDX_W) begin : g_bad_vec
      $error("VEC_W must exceed the input index width");
   end
   if (DATA_W < 8 || DATA_W < N_REQ || DATA_W < VEC_W) begin : g_bad_data
      $error("DATA_W too narrow for commands, mask or base");
   end

   setup_state_e       state_q;
   logic               need_mode_q;
   logic               sel_isr_q;
   logic [N_REQ-1:0]   irr_q, isr_q, imr_q;
   logic [BASE_W-1:0]  base_q;

   logic               cmd_wr, dat_wr, start_setup, eoi_cmd, rdsel_cmd;
   logic [N_REQ-1:0]   rise, pend, ack_set, eoi_clr;
   logic               pend_any, svc_any, ack;
   logic [IDX_W-1:0]   pend_idx, svc_idx;

   assign cmd_wr      = host_wr & ~host_addr;
   assign dat_wr      = host_wr &  host_addr;
   assign start_setup = cmd_wr & host_wdata[4];
   assign eoi_cmd     = cmd_wr & ~host_wdata[4] & ~host_wdata[3] &
                        (host_wdata[7:5] == EOI_TOP);
   assign rdsel_cmd   = cmd_wr & ~host_wdata[4] & host_wdata[3] & host_wdata[1];

   prio_irq_edge #(.WIDTH(N_REQ)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .level (irq_in),
      .rise  (rise)
   );

   assign pend = irr_q & ~imr_q;

   prio_irq_find #(.WIDTH(N_REQ)) u_pend_find (
      .req (pend),
      .any (pend_any),
      .idx (pend_idx)
   );

   prio_irq_find #(.WIDTH(N_REQ)) u_svc_find (
      .req (isr_q),
      .any (svc_any),
      .idx (svc_idx)
   );

   assign intr_o  = pend_any & (~svc_any | (pend_idx < svc_idx));
   assign ack     = inta_i & intr_o;
   assign ack_set = ack ? (N_REQ'(1) << pend_idx) : '0;
   assign eoi_clr = (eoi_cmd & svc_any) ? (N_REQ'(1) << svc_idx) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irr_q <= '0;
         isr_q <= '0;
      end else begin
         irr_q <= start_setup ? '0 : ((irr_q | rise) & ~ack_set);
         isr_q <= (isr_q & ~eoi_clr) | ack_set;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_READY;
         need_mode_q <= 1'b0;
         base_q      <= '0;
         imr_q       <= '0;
      end else if (start_setup) begin
         state_q     <= ST_BASE;
         need_mode_q <= host_wdata[0];
      end else if (dat_wr) begin
         unique case (state_q)
            ST_BASE: begin
               base_q  <= host_wdata[VEC_W-1:IDX_W];
               state_q <= ST_CASC;
            end
            ST_CASC:  state_q <= need_mode_q ? ST_MODE : ST_READY;
            ST_MODE:  state_q <= ST_READY;
            default:  imr_q   <= host_wdata[N_REQ-1:0];
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         sel_isr_q <= 1'b0;
      else if (rdsel_cmd) sel_isr_q <= host_wdata[0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   vec_o <= '0;
      else if (ack) vec_o <= {base_q, pend_idx};
   end

   always_comb begin
      if (host_addr)      host_rdata = DATA_W'(imr_q);
      else if (sel_isr_q) host_rdata = DATA_W'(isr_q);
      else                host_rdata = DATA_W'(irr_q);
   end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int N_REQ  = 8,
   parameter int VEC_W  = 8,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(N_REQ)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_addr,
   input logic [DATA_W-1:0] host_wdata,
   input logic              inta_i,
   input logic              intr_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic [N_REQ-1:0]  irr,
   input logic [N_REQ-1:0]  isr,
   input logic [N_REQ-1:0]  imr,
   input logic [VEC_W-IDX_W-1:0] base,
   input logic              ready
);
   logic eoi_wr, init_wr, mask_wr, good_ack;
   assign eoi_wr   = host_wr && !host_addr && (host_wdata[7:0] == 8'h20);
   assign init_wr  = host_wr && !host_addr && host_wdata[4];
   assign mask_wr  = host_wr && host_addr && ready;
   assign good_ack = inta_i && intr_o;

   AST_INTR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> ((irr & ~imr) != '0));                                  // R6
   AST_ACK_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (good_ack && !eoi_wr) |=> ($countones(isr) == $past($countones(isr)) + 1)); // R7
   AST_ACK_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      good_ack |=> (vec_o[VEC_W-1:IDX_W] == $past(base)));               // R7
   AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !good_ack |=> $stable(vec_o));                                     // R7
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(imr));                                        // R5
   AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !inta_i && (isr != '0)) |=> ($countones(isr) == $past($countones(isr)) - 1)); // R8
   AST_INIT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> (irr == '0));                                          // R3
endmodule

bind prio_irq_ctrl prio_irq_chk #(
   .N_REQ  (N_REQ),
   .VEC_W  (VEC_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .inta_i     (inta_i),
   .intr_o     (intr_o),
   .vec_o      (vec_o),
   .irr        (irr_q),
   .isr        (isr_q),
   .imr        (imr_q),
   .base       (base_q),
   .ready      (state_q == prio_irq_pkg::ST_READY)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_addr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [7:0] irq_in = '0;
   logic       intr_o;
   logic       inta_i = 1'b0;
   logic [7:0] vec_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_in(irq_in),
      .intr_o(intr_o), .inta_i(inta_i), .vec_o(vec_o)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic pulse(input int n);
      @(negedge clk);
      irq_in[n] = 1'b1;
      @(negedge clk);
      irq_in[n] = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      inta_i = 1'b1;
      @(negedge clk);
      inta_i = 1'b0;
   endtask

   task automatic rd_irr(output logic [7:0] d);
      wr(1'b0, 8'h0A);
      rd(1'b0, d);
   endtask

   task automatic rd_isr(output logic [7:0] d);
      wr(1'b0, 8'h0B);
      rd(1'b0, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 intr", {7'd0, intr_o}, 8'h00);
      chk("R1 vec", vec_o, 8'h00);
      rd(1'b1, d); chk("R1 mask", d, 8'h00);
      rd(1'b0, d); chk("R1 irr default select", d, 8'h00);
   endtask

   task automatic t_setup();
      logic [7:0] d;
      wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
      wr(1'b1, 8'hA5);
      rd(1'b1, d); chk("R2 R5 mask after mode word", d, 8'hA5);
      wr(1'b1, 8'h00);
      rd(1'b1, d); chk("R5 mask cleared", d, 8'h00);
   endtask

   task automatic t_single();
      logic [7:0] d;
      pulse(3);
      chk("R4 R6 intr on edge", {7'd0, intr_o}, 8'h01);
      rd(1'b0, d); chk("R4 R9 irr bit3", d, 8'h08);
      ack();
      chk("R7 vector", vec_o, 8'h23);
      chk("R7 intr after ack", {7'd0, intr_o}, 8'h00);
      rd_isr(d); chk("R7 R9 isr bit3", d, 8'h08);
      rd_irr(d); chk("R7 irr cleared", d, 8'h00);
      wr(1'b0, 8'h20);
      rd_isr(d); chk("R8 isr cleared", d, 8'h00);
   endtask

   task automatic t_nest();
      logic [7:0] d;
      pulse(3); ack();
      pulse(5);
      chk("R6 lower blocked", {7'd0, intr_o}, 8'h00);
      rd_irr(d); chk("R6 lower recorded", d, 8'h20);
      pulse(1);
      chk("R6 higher fires", {7'd0, intr_o}, 8'h01);
      ack();
      chk("R7 nested vector", vec_o, 8'h21);
      rd_isr(d); chk("R7 nested isr", d, 8'h0A);
      wr(1'b0, 8'h20);
      rd_isr(d); chk("R8 best isr cleared first", d, 8'h08);
      chk("R6 still blocked", {7'd0, intr_o}, 8'h00);
      wr(1'b0, 8'h20);
      chk("R8 release fires at once", {7'd0, intr_o}, 8'h01);
      ack();
      chk("R7 released vector", vec_o, 8'h25);
      wr(1'b0, 8'h20);
      rd_isr(d); chk("R8 all retired", d, 8'h00);
   endtask

   task automatic t_mask();
      logic [7:0] d;
      wr(1'b1, 8'h04);
      pulse(2);
      chk("R6 masked no intr", {7'd0, intr_o}, 8'h00);
      rd_irr(d); chk("R6 masked recorded", d, 8'h04);
      wr(1'b1, 8'h80);
      chk("R6 unmask fires", {7'd0, intr_o}, 8'h01);
      ack();
      chk("R7 vector after unmask", vec_o, 8'h22);
      rd(1'b1, d); chk("R5 mask kept by ack", d, 8'h80);
      wr(1'b0, 8'h20);
      rd(1'b1, d); chk("R5 mask kept by eoi", d, 8'h80);
      wr(1'b1, 8'h00);
   endtask

   task automatic t_hold();
      logic [7:0] d;
      @(negedge clk); irq_in[4] = 1'b1;
      @(negedge clk);
      chk("R4 held level fires", {7'd0, intr_o}, 8'h01);
      ack();
      chk("R7 held vector", vec_o, 8'h24);
      wr(1'b0, 8'h20);
      repeat (2) @(negedge clk);
      chk("R4 no retrigger", {7'd0, intr_o}, 8'h00);
      rd_irr(d); chk("R4 irr stays clear", d, 8'h00);
      irq_in[4] = 1'b0;
   endtask

   task automatic t_flush();
      logic [7:0] d;
      wr(1'b1, 8'h40);
      pulse(6);
      rd_irr(d); chk("R6 buffered before setup", d, 8'h40);
      wr(1'b0, 8'h10); wr(1'b1, 8'h48); wr(1'b1, 8'h00);
      wr(1'b1, 8'h12);
      rd(1'b1, d); chk("R2 no mode word expected", d, 8'h12);
      rd(1'b0, d); chk("R3 buffered request lost", d, 8'h00);
      chk("R3 no intr", {7'd0, intr_o}, 8'h00);
      wr(1'b1, 8'h00);
      pulse(7);
      ack();
      chk("R2 new base in vector", vec_o, 8'h4F);
      wr(1'b0, 8'h20);
   endtask

   task automatic t_idle_ack();
      logic [7:0] d;
      ack();
      chk("R7 idle ack keeps vector", vec_o, 8'h4F);
      rd_isr(d); chk("R7 idle ack no isr", d, 8'h00);
      wr(1'b0, 8'h0A);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_setup();
      t_single();
      t_nest();
      t_mask();
      t_hold();
      t_flush();
      t_idle_ack();
      repeat (2) @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule